// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two 18-bit ports, A and B, through two independent storage paths. The forward path carries A to B and the reverse path carries B to A. Each path has its own latch enable, its own strobe and its own output enable. When a path's latch enable is high, the path is transparent and the output follows the input at once. When the latch enable is low, the path holds its stored word. While the latch enable is low, a falling edge on the strobe loads a new word.

The forward output enable is active high and the reverse output enable is active low. A port in high impedance is represented by a data vector together with a valid flag, so no tri-state driver is needed.

All storage runs on the system clock `clk_i`. The strobe inputs are treated as data and sampled on that clock. A falling strobe edge is seen at the first system clock edge where the strobe is sampled low after having been sampled high. The output enable affects only the valid flag. The stored words keep updating while a port is disabled.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst_ni` is low, both stored words are cleared to zero. With a latch enable low after reset, the matching data output reads zero until something is loaded.
- R2: While `ab_le_i` is high, `b_o` equals `a_i` in the same cycle. While `ba_le_i` is high, `a_o` equals `b_i` in the same cycle.
- R3: When a latch enable falls, the output holds the input word sampled at the last system clock edge where that latch enable was high. It keeps that word while the strobe stays at a constant level, whatever the input does.
- R4: With the latch enable low, a system clock edge that samples the strobe low, after the previous edge sampled it high, loads the input word sampled at that edge. The output shows the new word from that edge on.
- R5: A rising strobe edge with the latch enable low loads nothing.
- R6: `b_oe_o` is 1 exactly when `ab_oe_i` is 1 (active high).
- R7: `a_oe_o` is 1 exactly when `ba_oe_ni` is 0 (active low).
- R8: A path keeps loading while its output enable is inactive. Once the output is enabled again, the word loaded during the disabled period is shown.
- R9: The controls and data of one path have no effect on the other path's output.
- R10: If the strobe is already low when the latch enable falls, a strobe that stays low leaves the output at the word held when the latch enable fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all controls |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Word driven onto port A from outside |
| b_i | input | 18 | Word driven onto port B from outside |
| ab_le_i | input | 1 | Forward latch enable (1 = transparent) |
| ab_clk_i | input | 1 | Forward strobe; loads on a falling edge |
| ab_oe_i | input | 1 | Forward output enable, active high |
| ba_le_i | input | 1 | Reverse latch enable (1 = transparent) |
| ba_clk_i | input | 1 | Reverse strobe; loads on a falling edge |
| ba_oe_ni | input | 1 | Reverse output enable, active low |
| b_o | output | 18 | Word presented on port B |
| b_oe_o | output | 1 | Port B driven (0 = high impedance) |
| a_o | output | 18 | Word presented on port A |
| a_oe_o | output | 1 | Port A driven (0 = high impedance) |

## Verification
The bench builds the block with its default width of 18. At that width, patterns such as alternating bits, all ones and a single top bit show a dropped, swapped or truncated bit anywhere in the word. Each path is driven through every row of its control table: transparent, held with the strobe high and with it low, the falling-edge load, and the ignored rising edge. The reverse path is run while the forward path changes, so any cross-coupling between the two shows up.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned DATA_W = 18;

  typedef enum logic {
    OE_ACT_HIGH = 1'b0,
    OE_ACT_LOW  = 1'b1
  } oe_pol_e;
endpackage

// File: rtl/ubt_fall_det.sv
module ubt_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
  parameter int unsigned WIDTH = ubt_pkg::DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic             le_i,
  input  logic             fall_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] word_q;

  // transparent phase keeps tracking so the last word survives le falling
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             word_q <= '0;
    else if (le_i || fall_i) word_q <= d_i;
  end

  assign q_o = le_i ? d_i : word_q;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int unsigned     WIDTH  = ubt_pkg::DATA_W,
  parameter ubt_pkg::oe_pol_e OE_POL = ubt_pkg::OE_ACT_HIGH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic             le_i,
  input  logic             strobe_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] q_o,
  output logic             drive_o
);
  logic fall;

  ubt_fall_det u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .fall_o  (fall)
  );

  ubt_store #(.WIDTH(WIDTH)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .le_i  (le_i),
    .fall_i(fall),
    .q_o   (q_o)
  );

  generate
    if (OE_POL == ubt_pkg::OE_ACT_LOW) begin : g_oe_low
      assign drive_o = ~oe_i;
    end else begin : g_oe_high
      assign drive_o = oe_i;
    end
  endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int unsigned WIDTH = ubt_pkg::DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_le_i,
  input  logic             ab_clk_i,
  input  logic             ab_oe_i,
  input  logic             ba_le_i,
  input  logic             ba_clk_i,
  input  logic             ba_oe_ni,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o
);
  ubt_lane #(.WIDTH(WIDTH), .OE_POL(ubt_pkg::OE_ACT_HIGH)) u_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (a_i),
    .le_i    (ab_le_i),
    .strobe_i(ab_clk_i),
    .oe_i    (ab_oe_i),
    .q_o     (b_o),
    .drive_o (b_oe_o)
  );

  ubt_lane #(.WIDTH(WIDTH), .OE_POL(ubt_pkg::OE_ACT_LOW)) u_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (b_i),
    .le_i    (ba_le_i),
    .strobe_i(ba_clk_i),
    .oe_i    (ba_oe_ni),
    .q_o     (a_o),
    .drive_o (a_oe_o)
  );
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int unsigned WIDTH = ubt_pkg::DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             ab_le_i,
  input logic             ab_clk_i,
  input logic             ba_le_i,
  input logic             ba_clk_i,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] a_o
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni && !ab_le_i) a_r1_fwd_clear: assert (b_o == '0);
    if (!rst_ni && !ba_le_i) a_r1_rev_clear: assert (a_o == '0);
  end

  a_r2_fwd_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |-> (b_o == a_i));
  a_r2_rev_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_le_i |-> (a_o == b_i));

  a_r3_fwd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !($past(ab_clk_i) && !ab_clk_i)) |=> (ab_le_i || $stable(b_o)));
  a_r3_rev_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && !($past(ba_clk_i) && !ba_clk_i)) |=> (ba_le_i || $stable(a_o)));

  a_r4_fwd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !ab_le_i && $past(ab_clk_i) && !ab_clk_i) |=> (ab_le_i || b_o == $past(a_i)));
  a_r4_rev_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !ba_le_i && $past(ba_clk_i) && !ba_clk_i) |=> (ba_le_i || a_o == $past(b_i)));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .ab_le_i (ab_le_i),
  .ab_clk_i(ab_clk_i),
  .ba_le_i (ba_le_i),
  .ba_clk_i(ba_clk_i),
  .b_o     (b_o),
  .a_o     (a_o)
);

// File: tb/ubt_xcvr_test.sv
`timescale 1ns/1ps
module ubt_xcvr_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         ab_le_i = 1'b0, ab_clk_i = 1'b0, ab_oe_i = 1'b0;
  logic         ba_le_i = 1'b0, ba_clk_i = 1'b0, ba_oe_ni = 1'b1;
  logic [W-1:0] b_o, a_o;
  logic         b_oe_o, a_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ubt_xcvr #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
    .ab_le_i(ab_le_i), .ab_clk_i(ab_clk_i), .ab_oe_i(ab_oe_i),
    .ba_le_i(ba_le_i), .ba_clk_i(ba_clk_i), .ba_oe_ni(ba_oe_ni),
    .b_o(b_o), .b_oe_o(b_oe_o), .a_o(a_o), .a_oe_o(a_oe_o)
  );

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // falling strobe: one edge samples high, next samples low
  task automatic fwd_load(logic [W-1:0] v);
    ab_clk_i = 1'b1; cyc();
    a_i = v; ab_clk_i = 1'b0; cyc();
  endtask

  task automatic rev_load(logic [W-1:0] v);
    ba_clk_i = 1'b1; cyc();
    b_i = v; ba_clk_i = 1'b0; cyc();
  endtask

  task automatic t_reset;
    cyc(2);
    check("R1 fwd during reset", b_o, 0);
    check("R1 rev during reset", a_o, 0);
    rst_ni = 1'b1; a_i = 18'h2AAAA; b_i = 18'h15555; cyc(2);
    check("R1 fwd after reset", b_o, 0);
    check("R1 rev after reset", a_o, 0);
  endtask

  task automatic t_transparent;
    ab_le_i = 1'b1; ba_le_i = 1'b1;
    a_i = 18'h3FFFF; b_i = 18'h00001; #1;
    check("R2 fwd ones", b_o, 18'h3FFFF);
    check("R2 rev one", a_o, 18'h00001);
    a_i = 18'h20000; b_i = 18'h2AAAA; #1;
    check("R2 fwd msb", b_o, 18'h20000);
    check("R2 rev alt", a_o, 18'h2AAAA);
    cyc();
  endtask

  task automatic t_hold;
    ab_le_i = 1'b1; ab_clk_i = 1'b1; a_i = 18'h12345; cyc();
    ab_le_i = 1'b0; a_i = 18'h0F0F0; cyc();
    check("R3 fwd hold clk high", b_o, 18'h12345);
    a_i = 18'h3C3C3; cyc(3);
    check("R3 fwd hold still", b_o, 18'h12345);
    ba_le_i = 1'b1; b_i = 18'h0ABCD; cyc();
    ba_le_i = 1'b0; b_i = 18'h3FFFF; cyc(2);
    check("R3 rev hold", a_o, 18'h0ABCD);
  endtask

  task automatic t_capture;
    fwd_load(18'h15555);
    check("R4 fwd load", b_o, 18'h15555);
    a_i = 18'h00000; cyc();
    check("R4 fwd after load", b_o, 18'h15555);
    rev_load(18'h2AAAA);
    check("R4 rev load", a_o, 18'h2AAAA);
    fwd_load(18'h3FFFF);
    check("R4 fwd second load", b_o, 18'h3FFFF);
  endtask

  task automatic t_rise;
    ab_clk_i = 1'b0; cyc();
    a_i = 18'h01234; ab_clk_i = 1'b1; cyc(2);
    check("R5 fwd rise ignored", b_o, 18'h3FFFF);
    ba_clk_i = 1'b0; cyc();
    b_i = 18'h04321; ba_clk_i = 1'b1; cyc(2);
    check("R5 rev rise ignored", a_o, 18'h2AAAA);
    ab_clk_i = 1'b0; ba_clk_i = 1'b0; cyc();
  endtask

  task automatic t_oe;
    ab_oe_i = 1'b1; ba_oe_ni = 1'b1; #1;
    check("R6 b driven", b_oe_o, 1);
    check("R7 a off", a_oe_o, 0);
    ab_oe_i = 1'b0; ba_oe_ni = 1'b0; #1;
    check("R6 b off", b_oe_o, 0);
    check("R7 a driven", a_oe_o, 1);
    cyc();
  endtask

  task automatic t_oe_store;
    ab_oe_i = 1'b0; ba_oe_ni = 1'b1;
    fwd_load(18'h0BEEF);
    rev_load(18'h1CAFE);
    ab_oe_i = 1'b1; ba_oe_ni = 1'b0; cyc();
    check("R8 fwd loaded while off", b_o, 18'h0BEEF);
    check("R8 rev loaded while off", a_o, 18'h1CAFE);
  endtask

  task automatic t_indep;
    ab_le_i = 1'b1; a_i = 18'h3FFFF; cyc();
    check("R9 rev unaffected by fwd transparent", a_o, 18'h1CAFE);
    ab_le_i = 1'b0; fwd_load(18'h00F00);
    check("R9 rev unaffected by fwd load", a_o, 18'h1CAFE);
    ba_le_i = 1'b1; b_i = 18'h22222; cyc();
    ba_le_i = 1'b0; cyc();
    check("R9 fwd unaffected by rev", b_o, 18'h00F00);
  endtask

  task automatic t_low_at_fall;
    ab_clk_i = 1'b0; ab_le_i = 1'b1; a_i = 18'h11111; cyc(2);
    ab_le_i = 1'b0; a_i = 18'h2EEEE; cyc();
    check("R10 fwd low strobe at le fall", b_o, 18'h11111);
    cyc(3);
    check("R10 fwd still held", b_o, 18'h11111);
    ba_clk_i = 1'b0; ba_le_i = 1'b1; b_i = 18'h05A5A; cyc(2);
    ba_le_i = 1'b0; b_i = 18'h3A5A5; cyc(3);
    check("R10 rev low strobe at le fall", a_o, 18'h05A5A);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_capture();
    t_rise();
    t_oe();
    t_oe_store();
    t_indep();
    t_low_at_fall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule